// File: doc/BRIEF.md
# Shared Execute-Stage Arbiter for Divide and Multiply-Accumulate Pipelines

This block decides, cycle by cycle, who owns the first execute stage of a floating-point multiply-accumulate pipeline. That stage is shared with an iterative divide/square-root pipeline. A divide or square root needs the shared stage only in the first cycle of each of its iterations. After that cycle it continues in its own E1 and E2 stages, and the shared stage is free for multiply-accumulate work.

Decoded instructions arrive one at a time. Each carries a kind and an iteration count. The arbiter raises `issue_ready` only when the instruction can start its first execute cycle in the very next cycle without a resource conflict. A host that sees `issue_ready` low holds its request until the arbiter raises it.

The arbiter tracks how many more cycles a multiply-accumulate instruction will hold the shared stage. It also tracks which iteration and which cycle the divide pipeline is in. It flags the cycle in which a divide's last iteration leaves E2, so that writeback can be scheduled. A short-vector divide runs its iterations back to back. It keeps any new multiply-accumulate instruction out until its final iteration has taken the shared stage.

Top module: `e1_share_arbiter`

## Requirements
- R1: After reset all stage and status outputs are low, and `issue_ready` is high for both kinds of instruction.
- R2: A multiply-accumulate instruction (`issue_kind` = 0) that is accepted with `issue_len` = L holds `shared_mac` high for exactly L+1 consecutive cycles, starting in the cycle after acceptance.
- R3: A divide (`issue_kind` = 1) that is accepted with `issue_len` = L runs L+1 iterations back to back. Each iteration lasts DIV_E1_CYCLES + DIV_E2_CYCLES cycles. `shared_div` and `div_e1` are both high in the first cycle of an iteration. Only `div_e1` is high for the rest of the E1 cycles. Only `div_e2` is high for the E2 cycles.
- R4: `shared_mac` and `shared_div` are never high in the same cycle.
- R5: While a scalar divide (L = 0) is in the cycles after its shared cycle, a multiply-accumulate instruction is accepted at once.
- R6: While a vector divide is running, a multiply-accumulate instruction is refused until the cycle in which the divide's last iteration holds the shared stage. The instruction is accepted in that cycle.
- R7: A new divide is refused while the divide pipeline is busy. The one exception is the divide's completion cycle, in which a new divide is accepted.
- R8: An instruction of either kind is refused while a multiply-accumulate instruction will still hold the shared stage in the next cycle.
- R9: `div_done` is high for exactly one cycle: the last E2 cycle of the last iteration. `div_busy` is high from the divide's first cycle through that cycle, and low afterwards unless a new divide was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| issue_valid | input | 1 | A decoded instruction is offered |
| issue_kind | input | 1 | 0 = multiply-accumulate, 1 = divide or square root |
| issue_len | input | LEN_W | Iteration count minus one |
| issue_ready | output | 1 | The offered instruction is accepted at this clock edge if valid |
| shared_mac | output | 1 | A multiply-accumulate iteration holds the shared E1 stage |
| shared_div | output | 1 | A divide iteration holds the shared E1 stage |
| div_e1 | output | 1 | The divide pipeline is in its E1 stage |
| div_e2 | output | 1 | The divide pipeline is in its E2 stage |
| div_done | output | 1 | The last divide iteration leaves E2 this cycle |
| div_busy | output | 1 | The divide pipeline holds a divide |

## Verification
The assertions assume a host that offers at most one instruction every other cycle. After an acceptance, `issue_valid` must be low in the following cycle. The assertions also assume that a refused request is held with the same kind and length until it is accepted. The bench keeps to both rules. It drops `issue_valid` in the cycle after each acceptance and raises the second request only one cycle later. It then holds that request steady while it checks the refusal window cycle by cycle against the acceptance cycle computed in the bench.

// File: rtl/e1arb_pkg.sv
package e1arb_pkg;
  typedef enum logic {
    OP_MAC = 1'b0,
    OP_DIV = 1'b1
  } op_kind_t;
endpackage

// File: rtl/e1arb_rst_sync.sv
module e1arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/e1arb_mac_track.sv
module e1arb_mac_track #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             active,
  output logic             free_next
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;
  logic             left_en;

  always_comb begin
    left_en = start || (left_q != '0);
    if (start) left_d = CNT_W'(len) + CNT_W'(1);
    else       left_d = left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign active    = (left_q != '0);
  assign free_next = (left_q <= CNT_W'(1));
endmodule

// File: rtl/e1arb_div_seq.sv
module e1arb_div_seq #(
  parameter int LEN_W         = 3,
  parameter int DIV_E1_CYCLES = 14,
  parameter int DIV_E2_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             in_shared,
  output logic             in_e1,
  output logic             in_e2,
  output logic             done,
  output logic             busy,
  output logic             block_mac,
  output logic             free_next
);
  localparam int LAT   = DIV_E1_CYCLES + DIV_E2_CYCLES;
  localparam int CYC_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam int CNT_W = LEN_W + 1;

  logic             act_q,  act_d;
  logic [CNT_W-1:0] iter_q, iter_d;
  logic [CYC_W-1:0] cyc_q,  cyc_d;
  logic             seq_en;
  logic             last_cyc, last_iter;

  assign last_cyc  = (cyc_q == CYC_W'(LAT - 1));
  assign last_iter = (iter_q == CNT_W'(1));

  always_comb begin
    seq_en = start || act_q;
    act_d  = act_q;
    iter_d = iter_q;
    cyc_d  = cyc_q;
    if (start) begin
      act_d  = 1'b1;
      iter_d = CNT_W'(len) + CNT_W'(1);
      cyc_d  = '0;
    end else if (act_q) begin
      if (last_cyc) begin
        cyc_d = '0;
        if (last_iter) act_d  = 1'b0;
        else           iter_d = iter_q - CNT_W'(1);
      end else begin
        cyc_d = cyc_q + CYC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      iter_q <= '0;
      cyc_q  <= '0;
    end else if (seq_en) begin
      act_q  <= act_d;
      iter_q <= iter_d;
      cyc_q  <= cyc_d;
    end
  end

  assign in_shared = act_q && (cyc_q == '0);
  assign in_e1     = act_q && (cyc_q <  CYC_W'(DIV_E1_CYCLES));
  assign in_e2     = act_q && (cyc_q >= CYC_W'(DIV_E1_CYCLES));
  assign done      = act_q && last_cyc && last_iter;
  assign busy      = act_q;
  assign block_mac = act_q && !last_iter;
  assign free_next = !act_q || done;
endmodule

// File: rtl/e1arb_issue_gate.sv
module e1arb_issue_gate
  import e1arb_pkg::*;
(
  input  op_kind_t kind,
  input  logic     mac_free_next,
  input  logic     div_block_mac,
  input  logic     div_free_next,
  output logic     ready
);
  logic mac_ok;
  logic div_ok;

  always_comb begin
    mac_ok = mac_free_next && !div_block_mac;
    div_ok = mac_free_next && div_free_next;
    ready  = (kind == OP_DIV) ? div_ok : mac_ok;
  end
endmodule

// File: rtl/e1_share_arbiter.sv
module e1_share_arbiter
  import e1arb_pkg::*;
#(
  parameter int LEN_W         = 3,
  parameter int DIV_E1_CYCLES = 14,
  parameter int DIV_E2_CYCLES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic             issue_kind,
  input  logic [LEN_W-1:0] issue_len,
  output logic             issue_ready,
  output logic             shared_mac,
  output logic             shared_div,
  output logic             div_e1,
  output logic             div_e2,
  output logic             div_done,
  output logic             div_busy
);
  logic     rst_n_sync;
  op_kind_t kind;
  logic     accept, mac_start, div_start;
  logic     mac_free_next, div_block_mac, div_free_next;

  assign kind      = op_kind_t'(issue_kind);
  assign accept    = issue_valid && issue_ready;
  assign mac_start = accept && (kind == OP_MAC);
  assign div_start = accept && (kind == OP_DIV);

  e1arb_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  e1arb_mac_track #(.LEN_W(LEN_W)) u_mac (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (mac_start),
    .len       (issue_len),
    .active    (shared_mac),
    .free_next (mac_free_next)
  );

  e1arb_div_seq #(
    .LEN_W         (LEN_W),
    .DIV_E1_CYCLES (DIV_E1_CYCLES),
    .DIV_E2_CYCLES (DIV_E2_CYCLES)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .start     (div_start),
    .len       (issue_len),
    .in_shared (shared_div),
    .in_e1     (div_e1),
    .in_e2     (div_e2),
    .done      (div_done),
    .busy      (div_busy),
    .block_mac (div_block_mac),
    .free_next (div_free_next)
  );

  e1arb_issue_gate u_gate (
    .kind          (kind),
    .mac_free_next (mac_free_next),
    .div_block_mac (div_block_mac),
    .div_free_next (div_free_next),
    .ready         (issue_ready)
  );
endmodule

// File: rtl/e1arb_checker.sv
module e1arb_checker (
  input logic clk,
  input logic rst_n,
  input logic issue_valid,
  input logic issue_kind,
  input logic issue_ready,
  input logic shared_mac,
  input logic shared_div,
  input logic div_e1,
  input logic div_e2,
  input logic div_done,
  input logic div_busy
);
  logic acc_mac, acc_div;
  assign acc_mac = issue_valid && issue_ready && !issue_kind;
  assign acc_div = issue_valid && issue_ready &&  issue_kind;

  // host rule: at most one instruction every other cycle
  host_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mac || acc_div) |=> !issue_valid);

  // R4
  shared_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shared_mac && shared_div));

  // R2
  mac_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mac |=> shared_mac);

  // R3
  div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_div |=> (shared_div && div_e1));

  // R3
  div_stage_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_e1 && div_e2));

  // R3
  shared_in_e1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shared_div |-> div_e1);

  // R7
  div_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !div_done) |-> !acc_div);

  // R9
  done_in_e2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (div_e2 && div_busy));

  // R9
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> (shared_div || !div_busy));
endmodule

bind e1_share_arbiter e1arb_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .issue_valid (issue_valid),
  .issue_kind  (issue_kind),
  .issue_ready (issue_ready),
  .shared_mac  (shared_mac),
  .shared_div  (shared_div),
  .div_e1      (div_e1),
  .div_e2      (div_e2),
  .div_done    (div_done),
  .div_busy    (div_busy)
);

// File: tb/e1_share_arbiter_test.sv
module e1_share_arbiter_test;
  localparam int LEN_W = 3;
  localparam int E1    = 14;
  localparam int E2    = 1;
  localparam int LAT   = E1 + E2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             issue_valid, issue_kind;
  logic [LEN_W-1:0] issue_len;
  logic             issue_ready, shared_mac, shared_div;
  logic             div_e1, div_e2, div_done, div_busy;

  int checks = 0;
  int failures = 0;

  e1_share_arbiter #(.LEN_W(LEN_W), .DIV_E1_CYCLES(E1), .DIV_E2_CYCLES(E2)) uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_kind(issue_kind),
    .issue_len(issue_len), .issue_ready(issue_ready), .shared_mac(shared_mac),
    .shared_div(shared_div), .div_e1(div_e1), .div_e2(div_e2),
    .div_done(div_done), .div_busy(div_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // packed observation: {shared_mac, shared_div, div_e1, div_e2, div_done, div_busy}
  function automatic int obs();
    return int'({shared_mac, shared_div, div_e1, div_e2, div_done, div_busy});
  endfunction

  function automatic int exp_solo(input int k, input int l, input int r);
    int n, c, v;
    if (k == 0) return (r >= 1 && r <= l + 1) ? 32 : 0;
    n = (l + 1) * LAT;
    if (r < 1 || r > n) return 0;
    c = (r - 1) % LAT;
    v = 1;
    if (c == 0) v += 16;
    if (c < E1) v += 8; else v += 4;
    if (r == n) v += 2;
    return v;
  endfunction

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!div_busy && !shared_mac) break;
    end
    @(negedge clk);
  endtask

  task automatic run_solo(input int k, input int l);
    int span;
    string req;
    req  = (k != 0) ? "R3 R9 divide trace" : "R2 R4 mac trace";
    span = (k != 0) ? (l + 1) * LAT : l + 1;
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = k[0]; issue_len = LEN_W'(l);
    #1 check("R1 ready when idle", int'(issue_ready), 1);
    for (int r = 1; r <= span + 2; r++) begin
      @(negedge clk);
      if (r == 1) issue_valid = 1'b0;
      check(req, obs(), exp_solo(k, l, r));
    end
    drain();
  endtask

  task automatic run_pair(input int k1, input int l1, input int k2, input int l2,
                          input int acc, input string req);
    @(negedge clk);
    issue_valid = 1'b1; issue_kind = k1[0]; issue_len = LEN_W'(l1);
    @(negedge clk);
    issue_valid = 1'b0;
    for (int r = 2; r <= acc; r++) begin
      @(negedge clk);
      issue_valid = 1'b1; issue_kind = k2[0]; issue_len = LEN_W'(l2);
      #1 check(req, int'(issue_ready), (r == acc) ? 1 : 0);
    end
    @(negedge clk);
    issue_valid = 1'b0;
    check({req, " R4 grant after accept"}, int'({shared_mac, shared_div}),
          (k2 == 0) ? 2 : 1);
    drain();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    issue_valid = 1'b0; issue_kind = 1'b0; issue_len = '0;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", obs(), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset, ready for both kinds
    check("R1 outputs after reset", obs(), 0);
    issue_kind = 1'b0;
    #1 check("R1 ready mac", int'(issue_ready), 1);
    issue_kind = 1'b1;
    #1 check("R1 ready div", int'(issue_ready), 1);

    for (int k = 0; k < 2; k++)
      for (int l = 0; l < 8; l++)
        run_solo(k, l);

    // R5 scalar divide / R6 vector divide followed by a mac
    for (int l1 = 0; l1 < 8; l1++) begin
      int acc;
      acc = (l1 * LAT + 1 > 2) ? l1 * LAT + 1 : 2;
      run_pair(1, l1, 0, 1, acc, (l1 == 0) ? "R5 mac during scalar div" : "R6 mac held by vector div");
    end

    // R7 divide after divide: accepted in the completion cycle
    for (int l1 = 0; l1 < 8; l1++)
      run_pair(1, l1, 1, 0, (l1 + 1) * LAT, "R7 div while div busy");

    // R8 any instruction behind a running mac
    for (int l1 = 0; l1 < 8; l1++)
      for (int k2 = 0; k2 < 2; k2++) begin
        int acc;
        acc = (l1 + 1 > 2) ? l1 + 1 : 2;
        run_pair(0, l1, k2, 2, acc, (k2 != 0) ? "R8 div behind mac" : "R8 R2 mac behind mac");
      end

    summary();
    $finish;
  end
endmodule